// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-and-ALU half of a simple processor in which every transfer travels over one internal word-wide bus. It contains the program counter, instruction register, memory address and memory data registers, three scratch registers (Y, Z, TEMP) and eight general-purpose registers. Each of these has a load strobe that captures the bus, and each that can source data has a drive strobe that puts its contents on the bus. The ALU takes operand A from a two-way choice between Y and the constant 4, and operand B straight from the bus. Its result lands only in Z.

All strobes are primary inputs, so an external control sequencer, which is not part of this block, steps the datapath one micro-operation per clock. The memory data register links the bus to the external read and write data lines. The memory address register drives the external address.

The bus is a one-hot selected AND-OR multiplexer rather than tri-states. When no source is enabled the bus reads zero. When two or more are enabled a conflict flag is raised.

Top module: `sbus_datapath`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears PC, MAR, MDR, IR, Y, Z, TEMP and all general-purpose registers to zero.
- R2: A register whose load strobe is high at a rising edge captures the bus value. With its load strobe low it keeps its value whatever the bus carries.
- R3: With exactly one drive strobe high, `bus` equals that register's value in the same cycle. With none high, `bus` is zero.
- R4: `bus_err` is high in exactly those cycles in which two or more drive strobes (pc_oe, mdr_oe, ir_oe, z_oe, tmp_oe, any gpr_oe bit) are high.
- R5: A single cycle with one source driving and several load strobes high copies the source into every selected destination. General-purpose register k uses bit k of `gpr_ld` and `gpr_oe`.
- R6: Operand A is the constant 4 when `sel_four` is 1 and register Y when it is 0. Z captures the ALU result when `z_ld` is high. Stepping the PC uses PC onto the bus, `sel_four`=1 and add.
- R7: `alu_op` encodes 0 = A+B+cin, 1 = A+~B+cin (A−B when `alu_cin`=1, A−B−1 when 0), 2 = A xor B, 3 = A and B, where B is the bus and cin is `alu_cin`.
- R8: With `mem_rd` high at an edge, MDR captures `mem_rdata`. This has priority over `mdr_ld`, which otherwise loads MDR from the bus. `mdr_oe` drives MDR onto the bus.
- R9: MAR loads only from the bus, and `mem_addr` always shows MAR. `mem_wdata` always shows MDR. `mem_we` and `mem_re` follow `mem_wr` and `mem_rd` in the same cycle.
- R10: `ir_q` always shows the instruction register, which loads from the bus under `ir_ld` and drives it under `ir_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| pc_ld | input | 1 | PC load from bus |
| pc_oe | input | 1 | PC drives bus |
| mar_ld | input | 1 | MAR load from bus |
| mdr_ld | input | 1 | MDR load from bus |
| mdr_oe | input | 1 | MDR drives bus |
| ir_ld | input | 1 | IR load from bus |
| ir_oe | input | 1 | IR drives bus |
| y_ld | input | 1 | Y load from bus |
| z_ld | input | 1 | Z load from ALU result |
| z_oe | input | 1 | Z drives bus |
| tmp_ld | input | 1 | TEMP load from bus |
| tmp_oe | input | 1 | TEMP drives bus |
| gpr_ld | input | NGPR | Per-register load strobes for the register file |
| gpr_oe | input | NGPR | Per-register drive strobes for the register file |
| sel_four | input | 1 | Operand A select: 1 = constant 4, 0 = Y |
| alu_op | input | 2 | ALU function code |
| alu_cin | input | 1 | ALU carry-in |
| mem_rd | input | 1 | Latch mem_rdata into MDR |
| mem_wr | input | 1 | Write request to memory |
| mem_rdata | input | W | External read data |
| mem_addr | output | W | External address (MAR) |
| mem_wdata | output | W | External write data (MDR) |
| mem_we | output | 1 | External write enable |
| mem_re | output | 1 | External read enable |
| ir_q | output | W | Instruction register contents for the decoder |
| bus | output | W | Internal bus value |
| bus_err | output | 1 | More than one bus driver enabled |

## Verification
The value checks on the bus assume a legal control word: at most one drive strobe is high. They are guarded by the conflict flag, so they are quiet whenever the sequencer breaks that rule. The checks on captured values assume that reset is not asserted in the cycle that follows the load. The directed stimulus raises two drive strobes together only inside the conflict scenario, and it reads every register back through a single-driver cycle. The only source from outside the bus is the memory read path, so every test value enters through MDR before it is moved elsewhere.

// File: rtl/sbus_datapath.sv
module sbus_datapath #(
  parameter int W    = 32,
  parameter int NGPR = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pc_ld,
  input  logic            pc_oe,
  input  logic            mar_ld,
  input  logic            mdr_ld,
  input  logic            mdr_oe,
  input  logic            ir_ld,
  input  logic            ir_oe,
  input  logic            y_ld,
  input  logic            z_ld,
  input  logic            z_oe,
  input  logic            tmp_ld,
  input  logic            tmp_oe,
  input  logic [NGPR-1:0] gpr_ld,
  input  logic [NGPR-1:0] gpr_oe,
  input  logic            sel_four,
  input  logic [1:0]      alu_op,
  input  logic            alu_cin,
  input  logic            mem_rd,
  input  logic            mem_wr,
  input  logic [W-1:0]    mem_rdata,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  output logic            mem_we,
  output logic            mem_re,
  output logic [W-1:0]    ir_q,
  output logic [W-1:0]    bus,
  output logic            bus_err
);
  localparam int NSRC = 5 + NGPR;

  logic [W-1:0] pc_q, mar_q, mdr_q, y_q, z_q, tmp_q;
  logic [W-1:0] ir_r;
  logic [W-1:0] gpr_q [NGPR];
  logic [NSRC-1:0] oe_vec;
  logic [W-1:0] src [NSRC];
  logic [W-1:0] opa, alu_y;

  assign oe_vec = {gpr_oe, tmp_oe, z_oe, ir_oe, mdr_oe, pc_oe};
  assign src[0] = pc_q;
  assign src[1] = mdr_q;
  assign src[2] = ir_r;
  assign src[3] = z_q;
  assign src[4] = tmp_q;

  for (genvar g = 0; g < NGPR; g++) begin : g_src
    assign src[5+g] = gpr_q[g];
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++)
      bus = bus | (src[i] & {W{oe_vec[i]}});
  end

  assign bus_err = $countones(oe_vec) > 1;

  assign opa = sel_four ? W'(4) : y_q;

  always_comb begin
    case (alu_op)
      2'd0:    alu_y = opa + bus + W'(alu_cin);
      2'd1:    alu_y = opa + ~bus + W'(alu_cin);
      2'd2:    alu_y = opa ^ bus;
      default: alu_y = opa & bus;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_r  <= '0;
      y_q   <= '0;
      z_q   <= '0;
      tmp_q <= '0;
    end else begin
      if (pc_ld)  pc_q  <= bus;
      if (mar_ld) mar_q <= bus;
      if (mem_rd) mdr_q <= mem_rdata;
      else if (mdr_ld) mdr_q <= bus;
      if (ir_ld)  ir_r  <= bus;
      if (y_ld)   y_q   <= bus;
      if (z_ld)   z_q   <= alu_y;
      if (tmp_ld) tmp_q <= bus;
    end
  end

  for (genvar g = 0; g < NGPR; g++) begin : g_gpr
    always_ff @(posedge clk) begin
      if (rst)            gpr_q[g] <= '0;
      else if (gpr_ld[g]) gpr_q[g] <= bus;
    end
  end

  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign mem_we    = mem_wr;
  assign mem_re    = mem_rd;
  assign ir_q      = ir_r;
endmodule

// File: rtl/sbus_datapath_chk.sv
module sbus_datapath_chk #(
  parameter int W    = 32,
  parameter int NSRC = 13
) (
  input logic            clk,
  input logic            rst,
  input logic [NSRC-1:0] oe_vec,
  input logic [W-1:0]    bus,
  input logic            bus_err,
  input logic            pc_ld,
  input logic            pc_oe,
  input logic [W-1:0]    pc_q,
  input logic            mar_ld,
  input logic [W-1:0]    mem_addr,
  input logic            mem_rd,
  input logic [W-1:0]    mem_rdata,
  input logic [W-1:0]    mdr_q,
  input logic            z_ld,
  input logic            sel_four,
  input logic [1:0]      alu_op,
  input logic            alu_cin,
  input logic [W-1:0]    z_q
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> (pc_q == '0 && z_q == '0 && mdr_q == '0 && mem_addr == '0));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst) !pc_ld |=> $stable(pc_q));

  // R2
  pc_load_chk: assert property (@(posedge clk) disable iff (rst) pc_ld |=> pc_q == $past(bus));

  // R3
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst) oe_vec == '0 |-> bus == '0);

  // R3
  pc_drive_chk: assert property (@(posedge clk) disable iff (rst) (pc_oe && !bus_err) |-> bus == pc_q);

  // R4
  conflict_chk: assert property (@(posedge clk) disable iff (rst) bus_err |-> !$onehot0(oe_vec));

  // R6
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (z_ld && sel_four && alu_op == 2'd0 && !alu_cin) |=> z_q == $past(bus) + W'(4));

  // R8
  mem_read_chk: assert property (@(posedge clk) disable iff (rst) mem_rd |=> mdr_q == $past(mem_rdata));

  // R9
  mar_load_chk: assert property (@(posedge clk) disable iff (rst) mar_ld |=> mem_addr == $past(bus));
endmodule

bind sbus_datapath sbus_datapath_chk #(.W(W), .NSRC(5 + NGPR)) u_chk (
  .clk(clk), .rst(rst),
  .oe_vec({gpr_oe, tmp_oe, z_oe, ir_oe, mdr_oe, pc_oe}),
  .bus(bus), .bus_err(bus_err),
  .pc_ld(pc_ld), .pc_oe(pc_oe), .pc_q(pc_q),
  .mar_ld(mar_ld), .mem_addr(mem_addr),
  .mem_rd(mem_rd), .mem_rdata(mem_rdata), .mdr_q(mdr_q),
  .z_ld(z_ld), .sel_four(sel_four), .alu_op(alu_op), .alu_cin(alu_cin), .z_q(z_q)
);

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
  localparam int W = 32;
  localparam int NGPR = 8;

  logic clk = 0, rst = 1;
  logic pc_ld, pc_oe, mar_ld, mdr_ld, mdr_oe, ir_ld, ir_oe, y_ld, z_ld, z_oe, tmp_ld, tmp_oe;
  logic [NGPR-1:0] gpr_ld, gpr_oe;
  logic sel_four, alu_cin, mem_rd, mem_wr;
  logic [1:0] alu_op;
  logic [W-1:0] mem_rdata, mem_addr, mem_wdata, ir_q, bus;
  logic mem_we, mem_re, bus_err;

  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  sbus_datapath #(.W(W), .NGPR(NGPR)) uut (.*);

  task automatic quiet();
    {pc_ld, pc_oe, mar_ld, mdr_ld, mdr_oe, ir_ld, ir_oe, y_ld, z_ld, z_oe, tmp_ld, tmp_oe} = '0;
    gpr_ld = '0; gpr_oe = '0; sel_four = 0; alu_cin = 0; alu_op = 2'd0;
    mem_rd = 0; mem_wr = 0; mem_rdata = '0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); quiet(); #1;
  endtask

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_mdr(logic [W-1:0] v);
    mem_rd = 1; mem_rdata = v; step();
  endtask

  task automatic t_reset();
    chk("R3 idle bus", bus, '0);
    chk("R4 idle err", W'(bus_err), '0);
    pc_oe = 1; #1 chk("R1 pc", bus, '0); quiet();
    mdr_oe = 1; #1 chk("R1 mdr", bus, '0); quiet();
    z_oe = 1; #1 chk("R1 z", bus, '0); quiet();
    tmp_oe = 1; #1 chk("R1 tmp", bus, '0); quiet();
    for (int k = 0; k < NGPR; k++) begin
      gpr_oe = NGPR'(1) << k; #1 chk("R1 gpr", bus, '0); quiet();
    end
    chk("R1 mar", mem_addr, '0);
    chk("R10 ir", ir_q, '0);
    #1;
  endtask

  task automatic t_move();
    put_mdr(32'h1234_5678);
    mdr_oe = 1; #1 chk("R3 mdr drive", bus, 32'h1234_5678);
    gpr_ld[3] = 1; step();
    gpr_oe[3] = 1; gpr_ld[4] = 1; gpr_ld[5] = 1; tmp_ld = 1; step();
    gpr_oe[4] = 1; #1 chk("R5 r4", bus, 32'h1234_5678); quiet();
    gpr_oe[5] = 1; #1 chk("R5 r5", bus, 32'h1234_5678); quiet();
    tmp_oe = 1; #1 chk("R5 tmp", bus, 32'h1234_5678); quiet();
    put_mdr(32'hCAFE_0001);
    mdr_oe = 1; step();
    gpr_oe[4] = 1; #1 chk("R2 hold r4", bus, 32'h1234_5678); quiet();
    gpr_oe[0] = 1; #1 chk("R2 r0 untouched", bus, '0); quiet();
    #1;
  endtask

  task automatic t_conflict();
    pc_oe = 1; z_oe = 1; #1 chk("R4 two drivers", W'(bus_err), 32'd1); quiet();
    gpr_oe = 8'b0000_0110; #1 chk("R4 two gprs", W'(bus_err), 32'd1); quiet();
    gpr_oe = 8'b0100_0000; #1 chk("R4 one driver", W'(bus_err), '0); quiet();
    #1;
  endtask

  task automatic alu_case(string req, logic [1:0] op, logic cin, logic four, logic [W-1:0] exp);
    mdr_oe = 1; alu_op = op; alu_cin = cin; sel_four = four; z_ld = 1; step();
    z_oe = 1; #1 chk(req, bus, exp); quiet();
  endtask

  task automatic t_alu();
    put_mdr(32'd10);
    mdr_oe = 1; y_ld = 1; step();
    put_mdr(32'd3);
    alu_case("R7 add", 2'd0, 0, 0, 32'd13);
    alu_case("R7 add cin", 2'd0, 1, 0, 32'd14);
    alu_case("R7 sub cin", 2'd1, 1, 0, 32'd7);
    alu_case("R7 sub no cin", 2'd1, 0, 0, 32'd6);
    alu_case("R7 xor", 2'd2, 0, 0, 32'd9);
    alu_case("R7 and", 2'd3, 0, 0, 32'd2);
    alu_case("R6 four", 2'd0, 0, 1, 32'd7);
    put_mdr(32'h0000_0100);
    mdr_oe = 1; pc_ld = 1; step();
    pc_oe = 1; sel_four = 1; z_ld = 1; step();
    z_oe = 1; pc_ld = 1; step();
    pc_oe = 1; #1 chk("R6 pc step", bus, 32'h0000_0104); quiet();
    #1;
  endtask

  task automatic t_mem();
    put_mdr(32'h0000_0A40);
    mdr_oe = 1; mar_ld = 1; step();
    chk("R9 addr", mem_addr, 32'h0000_0A40);
    mem_wr = 1; #1;
    chk("R9 we", W'(mem_we), 32'd1);
    chk("R9 wdata", mem_wdata, 32'h0000_0A40);
    quiet();
    mem_rd = 1; #1 chk("R9 re", W'(mem_re), 32'd1);
    mem_rdata = 32'hBEEF_0002; mdr_ld = 1; pc_oe = 1; step();
    chk("R8 rd priority", mem_wdata, 32'hBEEF_0002);
    pc_oe = 1; mdr_ld = 1; step();
    chk("R8 bus load", mem_wdata, 32'h0000_0104);
    mdr_oe = 1; ir_ld = 1; step();
    chk("R10 ir load", ir_q, 32'h0000_0104);
    ir_oe = 1; #1 chk("R10 ir drive", bus, 32'h0000_0104); quiet();
    #1;
  endtask

  task automatic t_midreset();
    rst = 1; step(); rst = 0; #1;
    pc_oe = 1; #1 chk("R1 pc cleared", bus, '0); quiet();
    gpr_oe[3] = 1; #1 chk("R1 gpr cleared", bus, '0); quiet();
    chk("R1 mar cleared", mem_addr, '0);
    chk("R1 ir cleared", ir_q, '0);
    sel_four = 0; z_ld = 1; step();
    z_oe = 1; #1 chk("R1 y cleared", bus, '0); quiet();
  endtask

  initial begin
    quiet();
    repeat (2) @(negedge clk);
    rst = 0; #1;
    t_reset();
    t_move();
    t_conflict();
    t_alu();
    t_mem();
    t_midreset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule